// File: doc/BRIEF.md
# Logic and Bit-Manipulation ALU Unit

This execution slice performs the Boolean and mask-driven bit operations of a 16-bit microcontroller core. A decoder presents an operation code, a size select, a first operand (an accumulator or memory value) and a second operand (a memory value or a bit mask), then pulses `start` for one cycle. On the next rising clock edge the unit registers a result, a write-back enable and the N, Z and V condition flags, and raises `done` for one cycle.

The unit covers AND, exclusive-OR and inclusive-OR in byte and word form. It also covers clearing or setting the bits selected by a mask, in byte or word form, and a bit test that only updates the flags. The carry flag is not produced here: the surrounding core keeps it unchanged for every operation of this unit. Fetch, decode, address generation, bus cycles and shifts live elsewhere.

Top module: `logic_bit_alu`

## Requirements
- R1: With `word`=0, operation codes 0 (AND), 1 (exclusive-OR) and 2 (inclusive-OR) combine bits [7:0] of `opnd_a` and `opnd_b`. `result`[7:0] takes the outcome, `result`[15:8] is 0 and `wr_en` is 1.
- R2: With `word`=1, codes 0, 1 and 2 combine all 16 bits of the operands into `result`, and `wr_en` is 1.
- R3: Code 3 (bit test) computes `opnd_a` AND `opnd_b` over bits [7:0] whatever `word` is, and sets the flags from that value. `wr_en` is 0 and `result` keeps its previous value.
- R4: Code 4 (clear bits) produces `opnd_a` AND NOT `opnd_b` at the selected size, with `wr_en`=1.
- R5: Code 5 (set bits) produces `opnd_a` OR `opnd_b` at the selected size, with `wr_en`=1.
- R6: `flag_n` takes bit 7 of the sized value for byte operations and bit 15 for word operations.
- R7: `flag_z` is 1 exactly when the sized value is all zeros. `flag_v` is 0 after every completed operation.
- R8: Result, flags and `wr_en` change on the rising edge at which `start` is sampled high, and `done` is 1 for the following cycle only. `wr_en` is never 1 without `done`, and outputs hold when no operation completes.
- R9: Codes 6 and 7 are reserved. With them, `start` produces no `done` and no `wr_en`, and `result` and the flags are left unchanged.
- R10: While `rst_n` is 0, `result`, the flags, `wr_en` and `done` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Issue strobe, one cycle per operation |
| op | input | 3 | Operation code (0..5 valid) |
| word | input | 1 | 1 selects 16-bit size, 0 selects 8-bit size |
| opnd_a | input | 16 | Accumulator or memory operand |
| opnd_b | input | 16 | Memory operand or bit mask |
| result | output | 16 | Registered result, upper byte 0 in byte mode |
| wr_en | output | 1 | Result is to be written back |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag (always cleared) |
| done | output | 1 | One-cycle completion pulse |

## Verification
An operation can issue in the very cycle that the previous one reports `done`, so one register update both retires an old result and loads a new one. The bench provokes this by holding `start` high on two consecutive cycles, first with a writing operation and then with a bit test. It then checks that `done` stays high in both cycles and that the second result does not disturb the first. It also checks that the bit test's flags appear while `result` still shows the earlier value.

// File: rtl/logic_bit_alu.sv
module logic_bit_alu #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [2:0]   op,
  input  logic         word,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  output logic [W-1:0] result,
  output logic         wr_en,
  output logic         flag_n,
  output logic         flag_z,
  output logic         flag_v,
  output logic         done
);
  localparam int HB = W / 2;
  localparam logic [2:0] OP_AND = 3'd0, OP_EOR = 3'd1, OP_OR = 3'd2,
                         OP_BIT = 3'd3, OP_CLR = 3'd4, OP_SET = 3'd5;

  logic [W-1:0] raw, sized;
  logic         valid, wide, is_test;

  assign valid   = (op <= OP_SET);
  assign is_test = (op == OP_BIT);
  assign wide    = word && !is_test;

  always_comb begin
    case (op)
      OP_AND, OP_BIT: raw = opnd_a & opnd_b;
      OP_EOR:         raw = opnd_a ^ opnd_b;
      OP_OR, OP_SET:  raw = opnd_a | opnd_b;
      OP_CLR:         raw = opnd_a & ~opnd_b;
      default:        raw = '0;
    endcase
  end

  assign sized = wide ? raw : {{(W-HB){1'b0}}, raw[HB-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '0;
      wr_en  <= 1'b0;
      flag_n <= 1'b0;
      flag_z <= 1'b0;
      flag_v <= 1'b0;
      done   <= 1'b0;
    end else begin
      done  <= start && valid;
      wr_en <= start && valid && !is_test;
      if (start && valid) begin
        if (!is_test) result <= sized;
        flag_n <= wide ? sized[W-1] : sized[HB-1];
        flag_z <= (sized == '0);
        flag_v <= 1'b0;
      end
    end
  end

  assert_wr_needs_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> done);
  assert_done_follows_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done);
  assert_test_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op == OP_BIT) |=> (done && !wr_en && $stable(result)));
  assert_byte_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !word && op != OP_BIT && valid) |=> (result[W-1:HB] == '0));
  assert_v_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !flag_v);
  assert_reserved_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !valid) |=> (!done && !wr_en && $stable(result) && $stable(flag_z)));
  assert_z_matches_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (flag_z == (result == '0)));
endmodule

// File: tb/logic_bit_alu_bench.sv
module logic_bit_alu_bench;
  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0, word = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [15:0] opnd_a = '0, opnd_b = '0, result;
  logic        wr_en, flag_n, flag_z, flag_v, done;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  logic_bit_alu u_logic_bit_alu (.clk, .rst_n, .start, .op, .word, .opnd_a, .opnd_b,
    .result, .wr_en, .flag_n, .flag_z, .flag_v, .done);

  // op[54:52] word[51] a[50:35] b[34:19] res[18:3] wr[2] n[1] z[0]
  localparam int NV = 11;
  localparam logic [54:0] VEC [NV] = '{
    {3'd0, 1'b0, 16'h12F3, 16'hAB3C, 16'h0030, 1'b1, 1'b0, 1'b0},
    {3'd1, 1'b0, 16'h0055, 16'h00AA, 16'h00FF, 1'b1, 1'b1, 1'b0},
    {3'd2, 1'b0, 16'h0000, 16'hFF00, 16'h0000, 1'b1, 1'b0, 1'b1},
    {3'd0, 1'b1, 16'hF0F0, 16'h8F0F, 16'h8000, 1'b1, 1'b1, 1'b0},
    {3'd1, 1'b1, 16'h1234, 16'h1234, 16'h0000, 1'b1, 1'b0, 1'b1},
    {3'd2, 1'b1, 16'h0100, 16'h0010, 16'h0110, 1'b1, 1'b0, 1'b0},
    {3'd4, 1'b0, 16'hFFFF, 16'h000F, 16'h00F0, 1'b1, 1'b1, 1'b0},
    {3'd4, 1'b1, 16'hFFFF, 16'h7FFF, 16'h8000, 1'b1, 1'b1, 1'b0},
    {3'd5, 1'b0, 16'h0000, 16'h0080, 16'h0080, 1'b1, 1'b1, 1'b0},
    {3'd5, 1'b1, 16'h0000, 16'h0000, 16'h0000, 1'b1, 1'b0, 1'b1},
    {3'd5, 1'b1, 16'h4000, 16'h0001, 16'h4001, 1'b1, 1'b0, 1'b0}
  };

  function automatic string tag(input logic [2:0] o, input logic w);
    if (o == 3'd4) return "R4";
    if (o == 3'd5) return "R5";
    return w ? "R2" : "R1";
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] o, input logic w, input logic [15:0] a, input logic [15:0] b);
    op = o; word = w; opnd_a = a; opnd_b = b; start = 1'b1;
  endtask

  task automatic outs(input string req, input logic [15:0] r, input logic we, input logic n, input logic z, input logic dn);
    chk(req, "result", 32'(result), 32'(r));
    chk(req, "wr_en", 32'(wr_en), 32'(we));
    chk("R6", "flag_n", 32'(flag_n), 32'(n));
    chk("R7", "flag_z", 32'(flag_z), 32'(z));
    chk("R7", "flag_v", 32'(flag_v), 32'(0));
    chk("R8", "done", 32'(done), 32'(dn));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    outs("R10", 16'h0, 1'b0, 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][54:52], VEC[i][51], VEC[i][50:35], VEC[i][34:19]);
      @(negedge clk);
      start = 1'b0;
      outs(tag(VEC[i][54:52], VEC[i][51]), VEC[i][18:3], VEC[i][2], VEC[i][1], VEC[i][0], 1'b1);
    end

    // R8: hold after the done pulse
    @(negedge clk);
    outs("R8", 16'h4001, 1'b0, 1'b0, 1'b0, 1'b0);

    // R3: bit test at byte size despite word=1; word AND would give N=1
    drive(3'd3, 1'b1, 16'h8001, 16'h8001);
    @(negedge clk);
    start = 1'b0;
    outs("R3", 16'h4001, 1'b0, 1'b0, 1'b0, 1'b1);
    drive(3'd3, 1'b0, 16'h00F0, 16'h000F);
    @(negedge clk);
    start = 1'b0;
    outs("R3", 16'h4001, 1'b0, 1'b0, 1'b1, 1'b1);

    // R9: reserved codes leave everything alone
    drive(3'd6, 1'b1, 16'hFFFF, 16'hFFFF);
    @(negedge clk);
    drive(3'd7, 1'b0, 16'h00FF, 16'h0000);
    @(negedge clk);
    start = 1'b0;
    outs("R9", 16'h4001, 1'b0, 1'b0, 1'b1, 1'b0);

    // R8: back-to-back issue, write then bit test
    drive(3'd2, 1'b1, 16'h8000, 16'h0F00);
    @(negedge clk);
    outs("R8", 16'h8F00, 1'b1, 1'b1, 1'b0, 1'b1);
    drive(3'd3, 1'b0, 16'h0000, 16'hFFFF);
    @(negedge clk);
    start = 1'b0;
    outs("R8", 16'h8F00, 1'b0, 1'b0, 1'b1, 1'b1);
    @(negedge clk);
    chk("R8", "done", 32'(done), 32'(0));

    // R6: byte N comes from bit 7 only
    drive(3'd1, 1'b0, 16'h8000, 16'h0000);
    @(negedge clk);
    start = 1'b0;
    outs("R6", 16'h0000, 1'b1, 1'b0, 1'b1, 1'b1);

    // R10: reset mid-run clears state
    rst_n = 1'b0;
    @(negedge clk);
    outs("R10", 16'h0, 1'b0, 1'b0, 1'b0, 1'b0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule